// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic stage of a small eight-bit datapath. Two operands and an operation code go in. The result comes back in the same cycle, with no register on the way. The second operand may come from a register or from an immediate field; the block does not care which. A six-bit status word is held in a register inside the block. The stored carry and zero bits feed the operations that chain across bytes.

Each operation writes only its own set of status bits on the clock edge where `op_valid` is high. The other bits keep their values. A compare leaves the result unused and drops the write-back strobe. Because the stored zero bit can only stay set or be cleared in a borrow-chained subtract or compare, a multi-byte compare can be built from one plain compare followed by chained compares.

Top module: `alu8_flags`

## Requirements
- R1: While `rst_n` is low, and after reset is released, `flags` reads 0. The status bits sit at fixed positions: [0]=C, [1]=Z, [2]=N, [3]=V, [4]=S, [5]=H.
- R2: OP_ADD returns a+b and OP_ADC returns a+b+C, using the stored carry. Both write all six bits. C is the carry out of bit 7, H is the carry out of bit 3, and V is two's-complement overflow.
- R3: OP_SUB returns a-b and OP_SBC returns a-b-C. Both write all six bits. C is the borrow out of bit 7, H is the borrow into bit 4, and V is signed overflow.
- R4: For OP_SBC and OP_CPC, Z becomes (result==0) AND the stored Z. Z is never newly set by these two operations.
- R5: OP_CMP and OP_CPC compute the same differences as OP_SUB and OP_SBC. They write all six bits and hold `result_we` low. Every other operation holds `result_we` high.
- R6: OP_AND, OP_OR, OP_XOR, OP_SETB (a|b) and OP_CLRB (a & ~b) write only Z, N, V and S. V is forced to 0, and C and H are kept.
- R7: OP_COM returns 0xFF-a and writes Z, N, V=0, S and C=1, keeping H. OP_NEG returns 0x00-a and writes all six bits, following the subtract rules.
- R8: OP_INC and OP_DEC write only Z, N, V and S, keeping C and H. V is set exactly when INC takes 0x7F to 0x80, or DEC takes 0x80 to 0x7F.
- R9: OP_LSL shifts in 0, and OP_ROL shifts in the stored C. Both move bit 7 into C and take H from bit 3 of the operand. Both write Z, N, V=N^C and the other bits listed here, but keep S.
- R10: OP_LSR shifts in 0, OP_ROR shifts the stored C into bit 7, and OP_ASR keeps bit 7. All three move bit 0 into C and write Z, N and V=N^C. They keep S and H.
- R11: OP_SWAP exchanges the two nibbles and leaves all six status bits unchanged.
- R12: Whenever S is written, it equals N XOR V.
- R13: With `op_valid` low, no status bit changes at the clock edge, whatever the op code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge |
| op_valid | input | 1 | Enables the status-bit update on this edge |
| op_i | input | 5 | Operation code, an `op_e` value from `alu8_pkg` |
| a_i | input | 8 | First operand (destination register value) |
| b_i | input | 8 | Second operand, register value or immediate |
| result_o | output | 8 | Combinational result |
| result_we | output | 1 | High when the result should be written back |
| flags | output | 6 | Registered status bits {H,S,V,N,Z,C} |

## Verification
Two things happen at the same clock edge. The status register takes the bits of one operation, and the next operation reads the stored carry and zero through the combinational path. The bench provokes this by issuing operations back to back with `op_valid` held high. It runs a 16-bit add as ADD then ADC, and two 16-bit compares as CMP then CPC: one with equal words and one that differs only in the low byte. For each step it judges the result in the same cycle and the status bits one edge later. The expected values are worked out by hand from the requirements. This shows that the carry and the sticky zero pass from one step to the next with no stale or early value.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int NFLAG = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  typedef logic [NFLAG-1:0] flags_t;

  typedef enum logic [4:0] {
    OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC, OP_NEG, OP_INC, OP_DEC,
    OP_AND, OP_OR, OP_XOR, OP_CLRB, OP_SETB, OP_COM,
    OP_LSL, OP_ROL, OP_LSR, OP_ROR, OP_ASR, OP_SWAP
  } op_e;

  // Which status bits each operation writes, as {H,S,V,N,Z,C}
  function automatic flags_t write_mask(op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC,
      OP_CMP, OP_CPC, OP_NEG:                 return 6'b111111;
      OP_AND, OP_OR, OP_XOR, OP_CLRB, OP_SETB,
      OP_INC, OP_DEC:                         return 6'b011110;
      OP_COM:                                 return 6'b011111;
      OP_LSL, OP_ROL:                         return 6'b101111;
      OP_LSR, OP_ROR, OP_ASR:                 return 6'b001111;
      default:                                return 6'b000000;
    endcase
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         c,
  output logic         h,
  output logic         v
);
  localparam int HALF = W / 2;

  logic [W-1:0]  x, y;
  logic          ci, sub;
  logic [W:0]    full;
  logic [HALF:0] half;

  always_comb begin
    x   = a;
    y   = b;
    ci  = 1'b0;
    sub = 1'b0;
    case (op)
      OP_ADC:         ci = cin;
      OP_SUB, OP_CMP: sub = 1'b1;
      OP_SBC, OP_CPC: begin sub = 1'b1; ci = cin; end
      OP_NEG:         begin sub = 1'b1; x = '0; y = a; end
      OP_INC:         y = W'(1);
      OP_DEC:         begin sub = 1'b1; y = W'(1); end
      default:        ;
    endcase
  end

  always_comb begin
    if (sub) begin
      full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, ci};
      half = {1'b0, x[HALF-1:0]} - {1'b0, y[HALF-1:0]} - {{HALF{1'b0}}, ci};
    end else begin
      full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
      half = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + {{HALF{1'b0}}, ci};
    end
    res = full[W-1:0];
    c   = full[W];
    h   = half[HALF];
    if (sub) v = (x[W-1] != y[W-1]) && (res[W-1] != x[W-1]);
    else     v = (x[W-1] == y[W-1]) && (res[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         c,
  output logic         h,
  output logic         v
);
  localparam int HALF = W / 2;

  logic shift;

  always_comb begin
    res   = '0;
    c     = 1'b0;
    h     = 1'b0;
    shift = 1'b0;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CLRB: res = a & ~b;
      OP_SETB: res = a | b;
      OP_COM:  begin res = ~a; c = 1'b1; end
      OP_LSL:  begin res = {a[W-2:0], 1'b0}; c = a[W-1]; h = a[HALF-1]; shift = 1'b1; end
      OP_ROL:  begin res = {a[W-2:0], cin};  c = a[W-1]; h = a[HALF-1]; shift = 1'b1; end
      OP_LSR:  begin res = {1'b0, a[W-1:1]};     c = a[0]; shift = 1'b1; end
      OP_ROR:  begin res = {cin, a[W-1:1]};      c = a[0]; shift = 1'b1; end
      OP_ASR:  begin res = {a[W-1], a[W-1:1]};   c = a[0]; shift = 1'b1; end
      OP_SWAP: res = {a[HALF-1:0], a[W-1:HALF]};
      default: ;
    endcase
    v = shift ? (res[W-1] ^ c) : 1'b0;
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  flags_t mask,
  input  flags_t newf,
  output flags_t flags_q
);
  flags_t flags_d;

  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    assign flags_d[i] = (en && mask[i]) ? newf[i] : flags_q[i];

    // R13 / per-operation subsets: an unwritten bit keeps its value
    p_keep_unwritten_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !(en && mask[i]) |=> flags_q[i] == $past(flags_q[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [4:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         result_we,
  output logic [5:0]   flags
);
  op_e          op;
  logic         rst_meta, rst_s;
  logic [W-1:0] ar_res, lg_res;
  logic         ar_c, ar_h, ar_v, lg_c, lg_h, lg_v;
  logic         use_arith, sticky_z, n_bit, z_bit, v_bit;
  flags_t       newf, mask, flags_q;

  assign op = op_e'(op_i);

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  alu8_arith #(.W(W)) i_arith (
    .op(op), .a(a_i), .b(b_i), .cin(flags_q[FC]),
    .res(ar_res), .c(ar_c), .h(ar_h), .v(ar_v));

  alu8_logic #(.W(W)) i_logic (
    .op(op), .a(a_i), .b(b_i), .cin(flags_q[FC]),
    .res(lg_res), .c(lg_c), .h(lg_h), .v(lg_v));

  always_comb begin
    use_arith = op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC,
                           OP_NEG, OP_INC, OP_DEC};
    sticky_z  = op inside {OP_SBC, OP_CPC};
    result_o  = use_arith ? ar_res : lg_res;
    result_we = !(op inside {OP_CMP, OP_CPC});
    n_bit     = result_o[W-1];
    v_bit     = use_arith ? ar_v : lg_v;
    z_bit     = (result_o == '0) && (!sticky_z || flags_q[FZ]);
    newf[FC]  = use_arith ? ar_c : lg_c;
    newf[FZ]  = z_bit;
    newf[FN]  = n_bit;
    newf[FV]  = v_bit;
    newf[FS]  = n_bit ^ v_bit;
    newf[FH]  = use_arith ? ar_h : lg_h;
    mask      = write_mask(op);
  end

  alu8_flagreg i_flagreg (
    .clk(clk), .rst_n(rst_s), .en(op_valid),
    .mask(mask), .newf(newf), .flags_q(flags_q));

  assign flags = flags_q;

  p_sign_rule_r12: assert property (@(posedge clk) disable iff (!rst_s)
    op_valid && mask[FS] |=> flags[FS] == (flags[FN] ^ flags[FV]));

  p_zero_sticky_r4: assert property (@(posedge clk) disable iff (!rst_s)
    op_valid && (op == OP_SBC || op == OP_CPC) && !flags[FZ] |=> !flags[FZ]);

  p_swap_quiet_r11: assert property (@(posedge clk) disable iff (!rst_s)
    op_valid && op == OP_SWAP |=> $stable(flags));

  p_logic_keep_r6: assert property (@(posedge clk) disable iff (!rst_s)
    op_valid && (op inside {OP_AND, OP_OR, OP_XOR, OP_CLRB, OP_SETB})
    |=> !flags[FV] && flags[FC] == $past(flags[FC]) && flags[FH] == $past(flags[FH]));

  p_com_carry_r7: assert property (@(posedge clk) disable iff (!rst_s)
    op_valid && op == OP_COM |=> flags[FC]);

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_s)
    !op_valid |=> $stable(flags));
endmodule

// File: tb/test_alu8_flags.sv
module test_alu8_flags;
  import alu8_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0;
  logic [7:0] result_o;
  logic       result_we;
  logic [5:0] flags;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  alu8_flags i_alu8_flags (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .result_we(result_we),
    .flags(flags));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // exp_f is {H,S,V,N,Z,C}; called at a falling edge
  task automatic run(input op_e op, input logic [7:0] a, input logic [7:0] b,
                     input logic [7:0] exp_r, input logic [5:0] exp_f,
                     input logic exp_we, input string req);
    op_i = op; a_i = a; b_i = b; op_valid = 1'b1;
    #1;
    chk(req, {op.name(), " result"}, result_o, exp_r);
    chk(req, {op.name(), " we"}, result_we, exp_we);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk(req, {op.name(), " flags"}, flags, exp_f);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    #1;
    chk("R1", "flags in reset", flags, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "flags after reset", flags, 0);
  endtask

  task automatic t_add;
    run(OP_ADD, 8'h0F, 8'h01, 8'h10, 6'b100000, 1'b1, "R2");
    run(OP_ADD, 8'h80, 8'h80, 8'h00, 6'b011011, 1'b1, "R2");
    run(OP_ADC, 8'h01, 8'h01, 8'h03, 6'b000000, 1'b1, "R2");
    run(OP_ADD, 8'h7F, 8'h01, 8'h80, 6'b101100, 1'b1, "R12");
    // 16-bit add 0x01FF + 0x0001, carry passed back to back
    run(OP_ADD, 8'hFF, 8'h01, 8'h00, 6'b100011, 1'b1, "R2");
    run(OP_ADC, 8'h01, 8'h00, 8'h02, 6'b000000, 1'b1, "R2");
  endtask

  task automatic t_sub;
    run(OP_SUB, 8'h10, 8'h01, 8'h0F, 6'b100000, 1'b1, "R3");
    run(OP_SUB, 8'h00, 8'h01, 8'hFF, 6'b110101, 1'b1, "R3");
    run(OP_SBC, 8'h05, 8'h02, 8'h02, 6'b000000, 1'b1, "R3");
    run(OP_CMP, 8'h80, 8'h01, 8'h7F, 6'b111000, 1'b0, "R5");
  endtask

  task automatic t_multibyte;
    run(OP_CMP, 8'h00, 8'h00, 8'h00, 6'b000010, 1'b0, "R5");
    run(OP_CPC, 8'h01, 8'h01, 8'h00, 6'b000010, 1'b0, "R4");
    run(OP_CMP, 8'h01, 8'h00, 8'h01, 6'b000000, 1'b0, "R5");
    run(OP_CPC, 8'h05, 8'h05, 8'h00, 6'b000000, 1'b0, "R4");
    run(OP_SBC, 8'h00, 8'h00, 8'h00, 6'b000000, 1'b1, "R4");
  endtask

  task automatic t_logic;
    run(OP_ADD, 8'h0F, 8'hF1, 8'h00, 6'b100011, 1'b1, "R2");
    run(OP_AND, 8'hF0, 8'h3C, 8'h30, 6'b100001, 1'b1, "R6");
    run(OP_OR, 8'h80, 8'h01, 8'h81, 6'b110101, 1'b1, "R6");
    run(OP_XOR, 8'hAA, 8'hAA, 8'h00, 6'b100011, 1'b1, "R6");
    run(OP_CLRB, 8'hFF, 8'h0F, 8'hF0, 6'b110101, 1'b1, "R6");
    run(OP_SETB, 8'h01, 8'h02, 8'h03, 6'b100001, 1'b1, "R6");
  endtask

  task automatic t_complement;
    run(OP_COM, 8'h55, 8'h00, 8'hAA, 6'b110101, 1'b1, "R7");
    run(OP_COM, 8'hFF, 8'h00, 8'h00, 6'b100011, 1'b1, "R7");
    run(OP_NEG, 8'h01, 8'h00, 8'hFF, 6'b110101, 1'b1, "R7");
    run(OP_NEG, 8'h80, 8'h00, 8'h80, 6'b001101, 1'b1, "R7");
    run(OP_NEG, 8'h00, 8'h00, 8'h00, 6'b000010, 1'b1, "R7");
  endtask

  task automatic t_incdec;
    run(OP_SUB, 8'h00, 8'h01, 8'hFF, 6'b110101, 1'b1, "R3");
    run(OP_INC, 8'h7F, 8'h00, 8'h80, 6'b101101, 1'b1, "R8");
    run(OP_DEC, 8'h80, 8'h00, 8'h7F, 6'b111001, 1'b1, "R8");
    run(OP_INC, 8'hFF, 8'h00, 8'h00, 6'b100011, 1'b1, "R8");
    run(OP_DEC, 8'h01, 8'h00, 8'h00, 6'b100011, 1'b1, "R8");
  endtask

  task automatic t_shift_left;
    run(OP_LSL, 8'h88, 8'h00, 8'h10, 6'b101001, 1'b1, "R9");
    run(OP_ROL, 8'h40, 8'h00, 8'h81, 6'b001100, 1'b1, "R9");
    run(OP_ROL, 8'h80, 8'h00, 8'h00, 6'b001011, 1'b1, "R9");
  endtask

  task automatic t_shift_right;
    run(OP_SUB, 8'h00, 8'h01, 8'hFF, 6'b110101, 1'b1, "R3");
    run(OP_LSR, 8'h01, 8'h00, 8'h00, 6'b111011, 1'b1, "R10");
    run(OP_ROR, 8'h02, 8'h00, 8'h81, 6'b111100, 1'b1, "R10");
    run(OP_ASR, 8'h81, 8'h00, 8'hC0, 6'b110101, 1'b1, "R10");
    run(OP_ASR, 8'h40, 8'h00, 8'h20, 6'b110000, 1'b1, "R10");
  endtask

  task automatic t_swap;
    run(OP_SWAP, 8'h3C, 8'h00, 8'hC3, 6'b110000, 1'b1, "R11");
  endtask

  task automatic t_hold;
    op_i = OP_ADD; a_i = 8'h80; b_i = 8'h80; op_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R13", "flags with op_valid low", flags, 6'b110000);
  endtask

  initial begin : watchdog
    #2_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_multibyte();
    t_logic();
    t_complement();
    t_incdec();
    t_shift_left();
    t_shift_right();
    t_swap();
    t_hold();
    rst_n = 1'b0;
    #1;
    chk("R1", "flags on reset reassert", flags, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule